// File: doc/BRIEF.md
# Inter-processor interrupt dispatcher

This block lets any of up to eight CPUs raise a software interrupt on any set of CPUs. The raising CPU presents one 32-bit generate word. That word holds a 4-bit interrupt ID, a delivery filter and an 8-bit target list. The block records one pending bit for every combination of receiving CPU, sending CPU and interrupt ID.

Each CPU has its own acknowledge strobe. While the strobe is high, the acknowledge word on that CPU's slice shows the interrupt the CPU would take: the lowest presentable ID, and among equal IDs the lowest sender. At the clock edge the pending bit is cleared and the ID becomes active on that CPU. The CPU later completes the interrupt in one of two ways. It can write the acknowledge word back on its end-of-interrupt port, or it can set the ID's bit on its clear-active port. If nothing can be presented, the acknowledge word carries a reserved spurious ID.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset nothing is pending or active, and `irqPending` is all zeros.
- R2: An acknowledge while nothing is presentable to that CPU returns 0x3FF (the spurious ID) and changes no state.
- R3: A presented acknowledge word carries the ID in bits [9:0], the sending CPU in bits [12:10], and zeros in all other bits.
- R4: Filter 0 (bits [25:24]) delivers to every CPU whose bit is set in the target list (bits [23:16]). Each targeted CPU acknowledges exactly once, and no other CPU ever sees the interrupt.
- R5: Filter 1 delivers to every CPU except the writer.
- R6: Filter 2 delivers only to the writer, whatever the target list holds.
- R7: Filter 3 delivers to nobody.
- R8: The ID comes from generate bits [3:0]. Bits [15:4] are ignored.
- R9: An acknowledge takes the lowest presentable ID. Among equal IDs it takes the lowest sending CPU.
- R10: An ID active on a CPU is not presented to that CPU again until it is deactivated. It may become pending again in the meantime.
- R11: An end-of-interrupt whose bits [9:0] hold an ID below 16 deactivates that ID on the writing CPU. The value 0x3FF has no effect.
- R12: Writing 1 to bit n of a CPU's clear-active port deactivates ID n on that CPU.
- R13: `irqPending[c]` is high exactly when CPU c has a presentable interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| genValid | input | 1 | Generate word strobe |
| genCpu | input | 3 | CPU that writes the generate word |
| genData | input | 32 | Generate word: filter, target list, ID |
| ackReq | input | NUM_CPUS | Per-CPU acknowledge strobe |
| ackData | output | NUM_CPUS*32 | Per-CPU acknowledge word (CPU c at slice c*32) |
| eoiValid | input | NUM_CPUS | Per-CPU end-of-interrupt strobe |
| eoiData | input | NUM_CPUS*32 | Per-CPU end-of-interrupt word |
| clrValid | input | NUM_CPUS | Per-CPU clear-active strobe |
| clrData | input | NUM_CPUS*16 | Per-CPU clear-active ID mask |
| irqPending | output | NUM_CPUS | Per-CPU presentable-interrupt flag |

## Verification
The hardest state to reach is an ID that is active on a CPU and pending on it again at the same time. Only in that state does the active mask alone decide what is presented. The stimulus acknowledges a self-targeted ID, raises it again, and confirms that the CPU reads spurious. It then releases the ID through the clear-active port, and in a separate pass through a genuine end-of-interrupt after an ignored spurious one. A three-sender pile-up on one CPU, with two senders sharing an ID, exercises the source tie-break and the active block together.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int MAX_CPUS    = 8;
  localparam int SRC_W       = 3;
  localparam int NUM_IDS     = 16;
  localparam int ID_W        = $clog2(NUM_IDS);
  localparam int ACK_ID_W    = 10;
  localparam int WORD_W      = 32;
  localparam int SPURIOUS_ID = 1023;
  localparam int FILT_LSB    = 24;
  localparam int LIST_LSB    = 16;

  typedef enum logic [1:0] {
    FILT_LIST   = 2'd0,
    FILT_OTHERS = 2'd1,
    FILT_SELF   = 2'd2,
    FILT_NONE   = 2'd3
  } filter_e;

  typedef struct packed {
    logic                               genFire;
    logic [SRC_W-1:0]                   genSrc;
    logic [ID_W-1:0]                    genId;
    logic [MAX_CPUS-1:0]                genTargets;
    logic [MAX_CPUS-1:0][NUM_IDS-1:0]   deact;
  } ctrlStrobes_t;
endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input  logic                        genValid,
  input  logic [SRC_W-1:0]            genCpu,
  input  logic [WORD_W-1:0]           genData,
  input  logic [NUM_CPUS-1:0]         eoiValid,
  input  logic [NUM_CPUS*WORD_W-1:0]  eoiData,
  input  logic [NUM_CPUS-1:0]         clrValid,
  input  logic [NUM_CPUS*NUM_IDS-1:0] clrData,
  output ctrlStrobes_t                strobes
);
  localparam logic [MAX_CPUS-1:0] CPU_MASK = MAX_CPUS'((1 << NUM_CPUS) - 1);

  filter_e                          filt;
  logic [MAX_CPUS-1:0]              selfBit;
  logic [MAX_CPUS-1:0]              listBits;
  logic [MAX_CPUS-1:0]              tgtRaw;
  logic [MAX_CPUS-1:0][NUM_IDS-1:0] deactVec;
  logic                             unusedGen;

  assign filt     = filter_e'(genData[FILT_LSB +: 2]);
  assign listBits = genData[LIST_LSB +: MAX_CPUS];
  assign selfBit  = MAX_CPUS'(1) << genCpu;
  assign unusedGen = ^{genData[WORD_W-1:FILT_LSB+2], genData[LIST_LSB-1:ID_W]};

  always_comb begin
    unique case (filt)
      FILT_LIST:   tgtRaw = listBits;
      FILT_OTHERS: tgtRaw = ~selfBit;
      FILT_SELF:   tgtRaw = selfBit;
      default:     tgtRaw = '0;
    endcase
  end

  // per-CPU completion decode: end-of-interrupt ID and clear-active mask
  for (genvar t = 0; t < MAX_CPUS; t++) begin : g_cpu
    if (t < NUM_CPUS) begin : g_live
      logic [ACK_ID_W-1:0] eoiId;
      logic [NUM_IDS-1:0]  eoiOne;
      logic [NUM_IDS-1:0]  clrMask;
      logic                unusedEoi;
      assign eoiId     = eoiData[t*WORD_W +: ACK_ID_W];
      assign unusedEoi = ^eoiData[t*WORD_W+ACK_ID_W +: WORD_W-ACK_ID_W];
      assign eoiOne    = (eoiValid[t] && (eoiId < NUM_IDS))
                         ? (NUM_IDS'(1) << eoiId[ID_W-1:0]) : '0;
      assign clrMask   = clrValid[t] ? clrData[t*NUM_IDS +: NUM_IDS] : '0;
      assign deactVec[t] = eoiOne | clrMask;
    end else begin : g_idle
      assign deactVec[t] = '0;
    end
  end

  always_comb begin
    strobes.genFire    = genValid && (int'(genCpu) < NUM_CPUS);
    strobes.genSrc     = genCpu;
    strobes.genId      = genData[ID_W-1:0];
    strobes.genTargets = tgtRaw & CPU_MASK;
    strobes.deact      = deactVec;
  end
endmodule

// File: rtl/ipi_arbiter.sv
module ipi_arbiter
  import ipi_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0][NUM_IDS-1:0] pend,
  input  logic [NUM_IDS-1:0]              active,
  output logic                            found,
  output logic [ID_W-1:0]                 selId,
  output logic [SRC_W-1:0]                selSrc
);
  // scan from the highest pair down so the lowest (ID, source) wins
  always_comb begin
    found  = 1'b0;
    selId  = '0;
    selSrc = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      for (int s = NUM_SRC - 1; s >= 0; s--) begin
        if (pend[s][i] && !active[i]) begin
          found  = 1'b1;
          selId  = ID_W'(i);
          selSrc = SRC_W'(s);
        end
      end
    end
  end
endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic [NUM_CPUS-1:0]        ackReq,
  output logic [NUM_CPUS*WORD_W-1:0] ackData,
  output logic [NUM_CPUS-1:0]        irqPending
);
  localparam int PAD_HI = WORD_W - ACK_ID_W - SRC_W;
  localparam int PAD_LO = ACK_ID_W - ID_W;

  logic [NUM_CPUS-1:0][NUM_CPUS-1:0][NUM_IDS-1:0] pendQ, pendD;
  logic [NUM_CPUS-1:0][NUM_IDS-1:0]               actQ, actD;
  logic [NUM_IDS-1:0]                             genOne;

  assign genOne = NUM_IDS'(1) << strobes.genId;

  for (genvar t = 0; t < NUM_CPUS; t++) begin : g_tgt
    logic               found;
    logic [ID_W-1:0]    selId;
    logic [SRC_W-1:0]   selSrc;
    logic               take;
    logic [NUM_IDS-1:0] takeOne;
    logic [WORD_W-1:0]  ackWord;
    logic               hitTgt;

    ipi_arbiter #(.NUM_SRC(NUM_CPUS)) u_arb (
      .pend   (pendQ[t]),
      .active (actQ[t]),
      .found  (found),
      .selId  (selId),
      .selSrc (selSrc)
    );

    assign take    = ackReq[t] & found;
    assign takeOne = take ? (NUM_IDS'(1) << selId) : '0;
    assign hitTgt  = strobes.genFire & strobes.genTargets[t];
    assign actD[t] = (actQ[t] & ~strobes.deact[t]) | takeOne;
    assign ackWord = {{PAD_HI{1'b0}}, selSrc, {PAD_LO{1'b0}}, selId};
    assign ackData[t*WORD_W +: WORD_W] = found ? ackWord : WORD_W'(SPURIOUS_ID);
    assign irqPending[t] = found;

    for (genvar s = 0; s < NUM_CPUS; s++) begin : g_src
      logic srcTake;
      logic srcGen;
      assign srcTake = (selSrc == SRC_W'(s));
      assign srcGen  = hitTgt && (strobes.genSrc == SRC_W'(s));
      // a new generate in the acknowledge cycle re-arms the bit
      assign pendD[t][s] = (pendQ[t][s] & ~(srcTake ? takeOne : '0))
                           | (srcGen ? genOne : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      actQ  <= '0;
    end else begin
      pendQ <= pendD;
      actQ  <= actD;
    end
  end
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        genValid,
  input  logic [SRC_W-1:0]            genCpu,
  input  logic [WORD_W-1:0]           genData,
  input  logic [NUM_CPUS-1:0]         ackReq,
  output logic [NUM_CPUS*WORD_W-1:0]  ackData,
  input  logic [NUM_CPUS-1:0]         eoiValid,
  input  logic [NUM_CPUS*WORD_W-1:0]  eoiData,
  input  logic [NUM_CPUS-1:0]         clrValid,
  input  logic [NUM_CPUS*NUM_IDS-1:0] clrData,
  output logic [NUM_CPUS-1:0]         irqPending
);
  ctrlStrobes_t strobes;

  ipi_ctrl #(.NUM_CPUS(NUM_CPUS)) u_ctrl (
    .genValid (genValid),
    .genCpu   (genCpu),
    .genData  (genData),
    .eoiValid (eoiValid),
    .eoiData  (eoiData),
    .clrValid (clrValid),
    .clrData  (clrData),
    .strobes  (strobes)
  );

  ipi_datapath #(.NUM_CPUS(NUM_CPUS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .ackReq     (ackReq),
    .ackData    (ackData),
    .irqPending (irqPending)
  );
endmodule

// File: rtl/ipi_dispatch_checker.sv
module ipi_dispatch_checker
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       genValid,
  input logic [SRC_W-1:0]           genCpu,
  input logic [WORD_W-1:0]          genData,
  input logic [NUM_CPUS-1:0]        ackReq,
  input logic [NUM_CPUS*WORD_W-1:0] ackData,
  input logic [NUM_CPUS-1:0]        eoiValid,
  input logic [NUM_CPUS-1:0]        clrValid,
  input logic [NUM_CPUS-1:0]        irqPending
);
  // R5: an all-but-self generate never makes the writer presentable
  assert_others_skip_writer_R5: assert property (@(posedge clk) disable iff (!rstN)
    (genValid && genData[25:24] == 2'd1 && !irqPending[genCpu]
     && !eoiValid[genCpu] && !clrValid[genCpu])
    |=> !irqPending[$past(genCpu)]);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_chk
    // R2: nothing presentable means the spurious word
    assert_spurious_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
      !irqPending[c] |-> ackData[c*WORD_W +: WORD_W] == WORD_W'(SPURIOUS_ID));

    // R3: presented words keep the reserved bits clear and a legal ID
    assert_ack_format_R3: assert property (@(posedge clk) disable iff (!rstN)
      irqPending[c] |-> (ackData[c*WORD_W+13 +: WORD_W-13] == '0)
                        && (ackData[c*WORD_W +: ACK_ID_W] < NUM_IDS));

    // R10: a taken interrupt is not offered again on the next cycle
    assert_no_reack_R10: assert property (@(posedge clk) disable iff (!rstN)
      (ackReq[c] && irqPending[c])
      |=> !(irqPending[c] && ackData[c*WORD_W +: WORD_W] == $past(ackData[c*WORD_W +: WORD_W])));

    // R13: presentability only appears after a generate or a deactivation
    assert_pending_cause_R13: assert property (@(posedge clk) disable iff (!rstN)
      (!irqPending[c] && !genValid && !eoiValid[c] && !clrValid[c]) |=> !irqPending[c]);

    // R7: a reserved filter raises nothing
    assert_reserved_filter_R7: assert property (@(posedge clk) disable iff (!rstN)
      (genValid && genData[25:24] == 2'd3 && !irqPending[c] && !eoiValid[c] && !clrValid[c])
      |=> !irqPending[c]);
  end
endmodule

bind ipi_dispatch ipi_dispatch_checker #(.NUM_CPUS(NUM_CPUS)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .genValid   (genValid),
  .genCpu     (genCpu),
  .genData    (genData),
  .ackReq     (ackReq),
  .ackData    (ackData),
  .eoiValid   (eoiValid),
  .clrValid   (clrValid),
  .irqPending (irqPending)
);

// File: tb/ipi_dispatch_bench.sv
module ipi_dispatch_bench;
  localparam int N = 8;
  localparam logic [31:0] SPUR = 32'h3FF;

  logic          clk = 1'b0;
  logic          rstN;
  logic          genValid;
  logic [2:0]    genCpu;
  logic [31:0]   genData;
  logic [N-1:0]  ackReq, eoiValid, clrValid;
  logic [N*32-1:0] eoiData;
  logic [N*16-1:0] clrData;
  logic [N*32-1:0] ackData;
  logic [N-1:0]  irqPending;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ipi_dispatch #(.NUM_CPUS(N)) u_ipi_dispatch (
    .clk(clk), .rstN(rstN), .genValid(genValid), .genCpu(genCpu), .genData(genData),
    .ackReq(ackReq), .ackData(ackData), .eoiValid(eoiValid), .eoiData(eoiData),
    .clrValid(clrValid), .clrData(clrData), .irqPending(irqPending)
  );

  function automatic logic [31:0] ackWord(input int src, input int id);
    return 32'((src << 10) | id);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic sendGen(input int w, input logic [31:0] d);
    @(negedge clk); genCpu = 3'(w); genData = d; genValid = 1'b1;
    @(negedge clk); genValid = 1'b0; genData = '0;
  endtask

  task automatic readAck(input int c, output logic [31:0] v);
    @(negedge clk); ackReq[c] = 1'b1;
    #1 v = ackData[c*32 +: 32];
    @(negedge clk); ackReq[c] = 1'b0;
  endtask

  task automatic sendEoi(input int c, input logic [31:0] v);
    @(negedge clk); eoiValid[c] = 1'b1; eoiData[c*32 +: 32] = v;
    @(negedge clk); eoiValid[c] = 1'b0;
  endtask

  task automatic sendClr(input int c, input logic [15:0] m);
    @(negedge clk); clrValid[c] = 1'b1; clrData[c*16 +: 16] = m;
    @(negedge clk); clrValid[c] = 1'b0;
  endtask

  task automatic expectAck(input int c, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    readAck(c, v);
    check(v == exp, tag, v, exp);
  endtask

  task automatic expectPend(input logic [N-1:0] exp, input string tag);
    #1 check(irqPending == exp, tag, 32'(irqPending), 32'(exp));
  endtask

  task automatic testReset;
    expectPend('0, "R1 reset pending");
    for (int c = 0; c < N; c++) expectAck(c, SPUR, "R2 idle ack spurious");
    expectPend('0, "R2 idle ack no state change");
  endtask

  task automatic testSelf;
    sendGen(1, 32'h02FF_0001);
    expectPend(8'h02, "R6 self only");
    expectAck(1, ackWord(1, 1), "R3 R6 self ack word");
    sendEoi(1, ackWord(1, 1));
    expectPend('0, "R11 self completed");
  endtask

  task automatic testList;
    sendGen(3, 32'h00A5_0005);
    expectPend(8'hA5, "R4 list targets");
    for (int c = 0; c < N; c++) begin
      if (c inside {0, 2, 5, 7}) begin
        expectAck(c, ackWord(3, 5), "R4 targeted ack");
        sendEoi(c, ackWord(3, 5));
        expectAck(c, SPUR, "R4 exactly once");
      end else begin
        expectAck(c, SPUR, "R4 untargeted quiet");
      end
    end
  endtask

  task automatic testOthers;
    sendGen(6, 32'h0100_0009);
    expectPend(8'hBF, "R5 all but writer");
    for (int c = 0; c < N; c++) begin
      if (c != 6) begin
        expectAck(c, ackWord(6, 9), "R5 others ack");
        sendEoi(c, ackWord(6, 9));
      end
    end
    expectPend('0, "R5 all completed");
  endtask

  task automatic testReserved;
    sendGen(4, 32'h03FF_0004);
    expectPend('0, "R7 reserved filter");
  endtask

  task automatic testIdField;
    sendGen(2, 32'h0200_FFF6);
    expectAck(2, ackWord(2, 6), "R8 id low bits only");
    sendEoi(2, ackWord(2, 6));
  endtask

  task automatic testOrder;
    sendGen(4, 32'h0001_0007);
    sendGen(2, 32'h0001_0007);
    sendGen(5, 32'h0001_0003);
    expectAck(0, ackWord(5, 3), "R9 lowest id first");
    expectAck(0, ackWord(2, 7), "R9 lowest source on tie");
    expectAck(0, SPUR, "R10 active id blocked");
    expectPend('0, "R13 blocked not presentable");
    sendEoi(0, ackWord(2, 7));
    expectPend(8'h01, "R11 eoi releases id");
    expectAck(0, ackWord(4, 7), "R9 second source later");
    sendEoi(0, ackWord(4, 7));
    sendEoi(0, ackWord(5, 3));
    expectAck(0, SPUR, "R11 all completed");
  endtask

  task automatic testRepend;
    sendGen(0, 32'h0200_0002);
    expectAck(0, ackWord(0, 2), "R10 first take");
    sendGen(0, 32'h0200_0002);
    expectPend('0, "R10 repended while active");
    sendClr(0, 16'h0004);
    expectPend(8'h01, "R12 clear active releases");
    expectAck(0, ackWord(0, 2), "R12 repended id taken");
    sendEoi(0, ackWord(0, 2));
    expectPend('0, "R11 done");
  endtask

  task automatic testEoiIgnore;
    sendGen(7, 32'h0200_0004);
    expectAck(7, ackWord(7, 4), "R11 take");
    sendGen(7, 32'h0200_0004);
    sendEoi(7, SPUR);
    expectPend('0, "R11 spurious eoi ignored");
    sendEoi(7, ackWord(7, 4));
    expectPend(8'h80, "R11 real eoi releases");
    expectAck(7, ackWord(7, 4), "R11 retake");
    sendEoi(7, ackWord(7, 4));
    expectPend('0, "R11 final");
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; genValid = 1'b0; genCpu = '0; genData = '0;
    ackReq = '0; eoiValid = '0; clrValid = '0; eoiData = '0; clrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    testReset();
    testSelf();
    testList();
    testOthers();
    testReserved();
    testIdField();
    testOrder();
    testRepend();
    testEoiIgnore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule